// File: doc/BRIEF.md
# Scratchpad-Aware Cacheable Access Classifier

This block sits in front of a cache controller and decides, for each processor access, whether that access is routed through the cache. It classifies the 32-bit address against a fixed map of four windows: a boot ROM window, a peripheral I/O window, a main RAM window and a scratchpad window. Boot ROM and RAM are cacheable. I/O is never cacheable.

The scratchpad window is special. Ordinary decoding treats it as non-cacheable. A promotion stage then marks every write into the scratchpad as cacheable, so that the cache keeps a duplicate of each line written there and can later repair a corrupted scratchpad line from that duplicate. Reads from the scratchpad always bypass the cache.

While the recovery input is high, a scratchpad write is also flagged for write-through, so the repaired data reaches the scratchpad and the cache at once. Every result is registered, so it appears one cycle after the access is presented.

Top module: `cache_route_decider`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is released if no access is presented, `out_valid`, `out_cacheable`, `out_region`, `out_unmapped` and `out_wthru` are all zero.
- R2: For a valid access, `out_region` is 0 for 0x00000000..0x1FFFFFFF (boot ROM), 1 for 0x20000000..0x3FFFFFFF (I/O), 2 for 0x40000000..0x7FFFFFFF (RAM), and 3 for 0x8E000000..0x8FFFFFFF (scratchpad). Both ends of each window are included.
- R3: A valid access to the boot ROM or RAM window, read or write, gives `out_cacheable` = 1.
- R4: A valid access to the I/O window, read or write, gives `out_cacheable` = 0.
- R5: A valid read (`acc_write` = 0) of the scratchpad window gives `out_cacheable` = 0, whatever the value of `recov_mode`.
- R6: A valid write (`acc_write` = 1) to the scratchpad window gives `out_cacheable` = 1.
- R7: A valid access to an address outside all four windows gives `out_unmapped` = 1, `out_cacheable` = 0 and `out_region` = 0. `out_unmapped` is 0 for any address inside a window.
- R8: `out_wthru` is 1 only for a valid scratchpad write presented while `recov_mode` = 1. It is 0 for every other access.
- R9: A cycle with `acc_valid` = 0 gives, one cycle later, `out_valid` = 0 and all other outputs 0. Address, direction and recovery inputs have no effect in such a cycle.
- R10: The outputs reflect the access sampled on the previous rising clock edge, which gives a latency of exactly one cycle, and `out_valid` is 1 after a valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| recov_mode | input | 1 | Scratchpad error-recovery phase active |
| out_valid | output | 1 | Registered result is valid |
| out_cacheable | output | 1 | Access goes through the cache |
| out_region | output | 2 | Window code: 0 ROM, 1 I/O, 2 RAM, 3 scratchpad |
| out_unmapped | output | 1 | Address lies outside every window |
| out_wthru | output | 1 | Scratchpad write during recovery, handled as write-through |

## Verification
The bench drives the first and last byte of every window, and the addresses just outside them, including the gap between 0x80000000 and 0x8DFFFFFF and the space above 0x8FFFFFFF. An off-by-one window compare would put these edge addresses into the wrong region or raise the unmapped flag wrongly. Scratchpad reads and writes are each applied with recovery on and with it off. A design that dropped the direction term would cache scratchpad reads, or fail to replicate scratchpad writes. A design that let recovery promote reads would cache a scratchpad read during recovery. Idle cycles carry scratchpad write addresses with recovery high, which catches outputs that ignore the valid qualifier.

// File: rtl/cache_route_pkg.sv
package cache_route_pkg;
  localparam int ADDR_W = 32;
  localparam int N_RGN  = 4;
  localparam int RC_W   = $clog2(N_RGN);

  typedef enum logic [RC_W-1:0] {
    RGN_ROM = 2'd0,
    RGN_IO  = 2'd1,
    RGN_RAM = 2'd2,
    RGN_SPM = 2'd3
  } region_e;

  typedef struct packed {
    logic            valid;
    logic            cacheable;
    logic [RC_W-1:0] region;
    logic            unmapped;
    logic            wthru;
  } verdict_t;
endpackage

// File: rtl/rgn_decode.sv
module rgn_decode
  import cache_route_pkg::*;
#(
  parameter int                    AW     = ADDR_W,
  parameter int                    NR     = N_RGN,
  parameter logic [NR*AW-1:0]      LO_TAB = '0,
  parameter logic [NR*AW-1:0]      HI_TAB = '0,
  parameter logic [NR-1:0]         CACHE_MAP = '0
) (
  input  logic [AW-1:0]          addr,
  output logic [NR-1:0]          hit,
  output logic [$clog2(NR)-1:0]  rgn,
  output logic                   base_cacheable,
  output logic                   miss
);
  localparam int CW = $clog2(NR);

  for (genvar i = 0; i < NR; i++) begin : g_win
    localparam logic [AW-1:0] LO   = LO_TAB[i*AW +: AW];
    localparam logic [AW-1:0] SPAN = HI_TAB[i*AW +: AW] - LO;
    logic [AW-1:0] offs;
    assign offs   = addr - LO;
    assign hit[i] = (offs <= SPAN);
  end

  always_comb begin
    rgn            = '0;
    base_cacheable = 1'b0;
    for (int k = NR - 1; k >= 0; k--) begin
      if (hit[k]) begin
        rgn            = CW'(k);
        base_cacheable = CACHE_MAP[k];
      end
    end
  end

  assign miss = ~|hit;
endmodule

// File: rtl/spm_promote.sv
module spm_promote (
  input  logic spm_hit,
  input  logic is_write,
  input  logic recov,
  input  logic base_cacheable,
  output logic cacheable,
  output logic wthru
);
  logic spm_wr;
  assign spm_wr    = spm_hit & is_write;
  assign cacheable = base_cacheable | spm_wr;
  assign wthru     = spm_wr & recov;
endmodule

// File: rtl/verdict_reg.sv
module verdict_reg
  import cache_route_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_t d,
  output verdict_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (d.valid) q <= d;
    else q <= '0;
  end
endmodule

// File: rtl/cache_route_decider.sv
module cache_route_decider
  import cache_route_pkg::*;
#(
  parameter logic [N_RGN*ADDR_W-1:0] WIN_LO = {32'h8E00_0000, 32'h4000_0000,
                                               32'h2000_0000, 32'h0000_0000},
  parameter logic [N_RGN*ADDR_W-1:0] WIN_HI = {32'h8FFF_FFFF, 32'h7FFF_FFFF,
                                               32'h3FFF_FFFF, 32'h1FFF_FFFF},
  parameter logic [N_RGN-1:0]        WIN_CACHE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              recov_mode,
  output logic              out_valid,
  output logic              out_cacheable,
  output logic [RC_W-1:0]   out_region,
  output logic              out_unmapped,
  output logic              out_wthru
);
  logic [N_RGN-1:0] hit;
  logic [RC_W-1:0]  rgn;
  logic             base_c, miss, fin_c, wt;
  verdict_t         d, q;

  rgn_decode #(
    .AW(ADDR_W), .NR(N_RGN), .LO_TAB(WIN_LO), .HI_TAB(WIN_HI), .CACHE_MAP(WIN_CACHE)
  ) u_dec (
    .addr(acc_addr), .hit(hit), .rgn(rgn), .base_cacheable(base_c), .miss(miss)
  );

  spm_promote u_prom (
    .spm_hit(hit[RGN_SPM]), .is_write(acc_write), .recov(recov_mode),
    .base_cacheable(base_c), .cacheable(fin_c), .wthru(wt)
  );

  always_comb begin
    d.valid     = acc_valid;
    d.cacheable = fin_c;
    d.region    = rgn;
    d.unmapped  = miss;
    d.wthru     = wt;
  end

  verdict_reg u_reg (.clk(clk), .rst(rst), .d(d), .q(q));

  assign out_valid     = q.valid;
  assign out_cacheable = q.cacheable;
  assign out_region    = q.region;
  assign out_unmapped  = q.unmapped;
  assign out_wthru     = q.wthru;
endmodule

// File: rtl/cache_route_checker.sv
module cache_route_checker (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic        acc_write,
  input logic        recov_mode,
  input logic        out_valid,
  input logic        out_cacheable,
  input logic [1:0]  out_region,
  input logic        out_unmapped,
  input logic        out_wthru
);
  logic in_spm, in_io;
  assign in_spm = (acc_addr[31:25] == 7'b1000_111);
  assign in_io  = (acc_addr[31:29] == 3'b001);

  assert_spm_read_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_spm && !acc_write) |=> (!out_cacheable && out_region == 2'd3));
  assert_spm_write_cached_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_spm && acc_write) |=> (out_cacheable && out_valid));
  assert_io_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_io) |=> (!out_cacheable && out_region == 2'd1));
  assert_unmapped_uncached_R7: assert property (@(posedge clk) disable iff (rst)
    out_unmapped |-> (!out_cacheable && out_region == 2'd0 && out_valid));
  assert_wthru_only_spm_R8: assert property (@(posedge clk) disable iff (rst)
    out_wthru |-> (out_cacheable && out_region == 2'd3 && out_valid));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!out_valid && !out_cacheable && !out_wthru && !out_unmapped));
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
endmodule

bind cache_route_decider cache_route_checker u_chk (.*);

// File: tb/tb_cache_route_decider.sv
module tb_cache_route_decider;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write, recov_mode;
  logic [31:0] acc_addr;
  logic        out_valid, out_cacheable, out_unmapped, out_wthru;
  logic [1:0]  out_region;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_route_decider dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .recov_mode(recov_mode), .out_valid(out_valid),
    .out_cacheable(out_cacheable), .out_region(out_region),
    .out_unmapped(out_unmapped), .out_wthru(out_wthru)
  );

  // expected {valid, cacheable, region[1:0], unmapped, wthru}
  function automatic logic [5:0] model(input logic v, input logic [31:0] a,
                                       input logic w, input logic rc);
    logic [1:0] r;
    logic c, u, t;
    if (!v) return 6'b0;
    u = 1'b0; t = 1'b0; c = 1'b0; r = 2'd0;
    if (a <= 32'h1FFF_FFFF) begin r = 2'd0; c = 1'b1; end
    else if (a <= 32'h3FFF_FFFF) r = 2'd1;
    else if (a <= 32'h7FFF_FFFF) begin r = 2'd2; c = 1'b1; end
    else if (a >= 32'h8E00_0000 && a <= 32'h8FFF_FFFF) begin
      r = 2'd3; c = w; t = w & rc;
    end else u = 1'b1;
    return {1'b1, c, r, u, t};
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic w, input logic v);
    if (!v) return "R9";
    if (a >= 32'h8E00_0000 && a <= 32'h8FFF_FFFF) return w ? "R6/R8" : "R5/R8";
    if (a >= 32'h2000_0000 && a <= 32'h3FFF_FFFF) return "R4/R2";
    if (a >= 32'h8000_0000) return "R7";
    return "R3/R2";
  endfunction

  task automatic apply(input logic v, input logic [31:0] a, input logic w,
                       input logic rc, input string tag);
    logic [5:0] exp, got;
    acc_valid = v; acc_addr = a; acc_write = w; recov_mode = rc;
    @(negedge clk);
    exp = model(v, a, w, rc);
    got = {out_valid, out_cacheable, out_region, out_unmapped, out_wthru};
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s addr=%h wr=%0b rec=%0b v=%0b actual=%b expected=%b (R10 latency)",
               tag, a, w, rc, v, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lo_t [4];
    logic [31:0] hi_t [4];
    lo_t = '{32'h0000_0000, 32'h2000_0000, 32'h4000_0000, 32'h8E00_0000};
    hi_t = '{32'h1FFF_FFFF, 32'h3FFF_FFFF, 32'h7FFF_FFFF, 32'h8FFF_FFFF};
    void'($urandom(32'd4711));
    rst = 1'b1; acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0; recov_mode = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({out_valid, out_cacheable, out_region, out_unmapped, out_wthru} !== 6'b0) begin
      n_err++;
      $display("FAIL R1 reset actual=%b expected=000000",
               {out_valid, out_cacheable, out_region, out_unmapped, out_wthru});
    end
    rst = 1'b0;
    apply(1'b0, 32'h8E00_0000, 1'b1, 1'b1, "R1");

    // window edges, both directions, recovery on and off (R2 R3 R4 R5 R6 R8)
    for (int i = 0; i < 4; i++)
      for (int m = 0; m < 4; m++) begin
        apply(1'b1, lo_t[i], m[0], m[1], tag_of(lo_t[i], m[0], 1'b1));
        apply(1'b1, hi_t[i], m[0], m[1], tag_of(hi_t[i], m[0], 1'b1));
      end
    // just outside windows (R7)
    apply(1'b1, 32'h8000_0000, 1'b1, 1'b0, "R7");
    apply(1'b1, 32'h8DFF_FFFF, 1'b1, 1'b1, "R7");
    apply(1'b1, 32'h9000_0000, 1'b0, 1'b1, "R7");
    apply(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7");
    // idle with scratchpad write + recovery on the bus (R9)
    apply(1'b0, 32'h8F00_0010, 1'b1, 1'b1, "R9");
    apply(1'b0, 32'h0000_0040, 1'b0, 1'b0, "R9");
    // back-to-back alternation (R10)
    apply(1'b1, 32'h8E00_1000, 1'b0, 1'b1, "R5 R10");
    apply(1'b1, 32'h8E00_1000, 1'b1, 1'b1, "R8 R10");
    apply(1'b1, 32'h8E00_1000, 1'b0, 1'b1, "R5 R10");

    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [31:0] a;
      sel = int'($urandom % 6);
      if (sel < 4) a = lo_t[sel] + ($urandom % (hi_t[sel] - lo_t[sel] + 32'd1));
      else a = $urandom;
      begin
        logic v, w, rc;
        v = ($urandom % 8) != 0;
        w = $urandom % 2;
        rc = $urandom % 2;
        apply(v, a, w, rc, tag_of(a, w, v));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule